// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches the 32 input pins of one general-purpose I/O port and raises a single interrupt line toward the CPU when a pin event is both pending and unmasked. Every pin is first passed through a two-flop synchroniser. By default a pin reports any change of its synchronised value. A per-pin extended mode replaces this with one of four tests: a rising edge, a falling edge, a high level or a low level.

Software controls the block through a small word-addressed register interface. Each configuration vector (mask, extended mode, level/edge select and polarity) is held in a flip-flop bank. Software changes a bank only by writing ones to its set address or its clear address, and can read the bank back at a third address. Pending events collect in a status vector. Reading the status vector returns its contents and empties it in the same access.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Each bank has its own addresses. Mask: set 0x0, clear 0x1, read 0x2. Extended mode: set 0x4, clear 0x5, read 0x6. Level select (1 = level, 0 = edge): set 0x7, clear 0x8, read 0x9. Polarity (1 = rising/high, 0 = falling/low): set 0xA, clear 0xB, read 0xC. A write to a set address makes every bank bit whose wdata bit is 1 equal to 1. A write to a clear address makes every such bit 0.
- R2: A read at address 0x3 returns the pending status vector, and that access clears every status bit that has no new event in the same cycle.
- R3: irq_o is high exactly when some pin has both its status bit and its mask bit set. A change to the mask takes effect on irq_o in the cycle after the write.
- R4: When a pin's extended-mode bit is 0, any change of its input latches its status bit. The bit becomes visible on the third rising clock edge after the input changes.
- R5: When a pin is in extended edge mode, it latches only on a rising edge if its polarity bit is 1, and only on a falling edge if its polarity bit is 0.
- R6: When a pin is in extended level mode, its status bit is set again on every cycle while the active level (high when polarity is 1, low when polarity is 0) persists. A status read therefore does not clear it.
- R7: When a pin event and a status read fall in the same cycle, the read returns the old vector and the pin's status bit is set afterwards.
- R8: After reset all banks and the status vector are zero and irq_o is low.
- R9: Zero bits in a set or clear write leave the bank unchanged. Writing all ones to the mask clear address masks every pin.
- R10: rdata is zero whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational while rd_en is high |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
Two functions can fall in the same cycle: a pin event being latched, and the clear caused by a status read. The bench raises a pin and then issues the status read so that it occupies exactly the cycle in which the synchronised edge is detected. That read must return the bit as still clear, and the next read must return it as set. Level mode produces the same collision on every cycle, and it is judged by two back-to-back reads that both return the active pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      RA_MASK_SET  = 4'h0,
      RA_MASK_CLR  = 4'h1,
      RA_MASK      = 4'h2,
      RA_STATUS    = 4'h3,
      RA_XMODE_SET = 4'h4,
      RA_XMODE_CLR = 4'h5,
      RA_XMODE     = 4'h6,
      RA_LEVEL_SET = 4'h7,
      RA_LEVEL_CLR = 4'h8,
      RA_LEVEL     = 4'h9,
      RA_POL_SET   = 4'hA,
      RA_POL_CLR   = 4'hB,
      RA_POL       = 4'hC
   } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= async_i;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_setclr.sv
module gpio_irq_setclr #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_stb,
   input  logic             clr_stb,
   input  logic [WIDTH-1:0] bits_i,
   output logic [WIDTH-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= '0;
      else if (set_stb) q_o <= q_o | bits_i;
      else if (clr_stb) q_o <= q_o & ~bits_i;
   end

   // R1
   set_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((q_o & $past(bits_i)) == $past(bits_i)));
   // R1
   clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb) |=> ((q_o & $past(bits_i)) == '0));
   // R9
   zero_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb || clr_stb) |=> ((q_o & ~$past(bits_i)) == ($past(q_o) & ~$past(bits_i))));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_i,
   input  logic [WIDTH-1:0] xmode_i,
   input  logic [WIDTH-1:0] level_i,
   input  logic [WIDTH-1:0] polhi_i,
   output logic [WIDTH-1:0] event_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_i;
   end

   genvar p;
   generate
      for (p = 0; p < WIDTH; p++) begin : g_pin
         logic rise, fall, act_lvl;
         assign rise    =  sync_i[p] & ~prev_q[p];
         assign fall    = ~sync_i[p] &  prev_q[p];
         assign act_lvl = polhi_i[p] ? sync_i[p] : ~sync_i[p];
         always_comb begin
            if (!xmode_i[p])     event_o[p] = rise | fall;
            else if (level_i[p]) event_o[p] = act_lvl;
            else                 event_o[p] = polhi_i[p] ? rise : fall;
         end
      end
   endgenerate

   // R5
   edge_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((event_o & xmode_i & ~level_i & polhi_i & ~sync_i) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NPIN   = 32,
   parameter int DATA_W = 32,
   parameter int SYNC_N = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPIN-1:0]      pin_i,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic                 irq_o
);
   generate
      if (NPIN < 1 || NPIN > DATA_W) begin : g_bad_npin
         $error("gpio_irq_ctrl: NPIN must lie in 1..DATA_W");
      end
   endgenerate

   localparam int NBANK = 4;
   localparam int BK_MASK = 0, BK_XMODE = 1, BK_LEVEL = 2, BK_POL = 3;

   logic [NPIN-1:0] sync_w, ev_w, status_q;
   logic [NPIN-1:0] bank_q [NBANK];
   logic [NPIN-1:0] wbits;
   logic            rd_stat;

   assign wbits   = wdata[NPIN-1:0];
   assign rd_stat = rd_en && (addr == RA_STATUS);

   gpio_irq_sync #(.WIDTH(NPIN), .STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(sync_w));

   localparam logic [ADDR_W-1:0] SET_A [NBANK] = '{RA_MASK_SET, RA_XMODE_SET, RA_LEVEL_SET, RA_POL_SET};
   localparam logic [ADDR_W-1:0] CLR_A [NBANK] = '{RA_MASK_CLR, RA_XMODE_CLR, RA_LEVEL_CLR, RA_POL_CLR};

   genvar b;
   generate
      for (b = 0; b < NBANK; b++) begin : g_bank
         gpio_irq_setclr #(.WIDTH(NPIN)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .set_stb(wr_en && (addr == SET_A[b])),
            .clr_stb(wr_en && (addr == CLR_A[b])),
            .bits_i(wbits), .q_o(bank_q[b]));
      end
   endgenerate

   gpio_irq_detect #(.WIDTH(NPIN)) u_det (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_w),
      .xmode_i(bank_q[BK_XMODE]), .level_i(bank_q[BK_LEVEL]),
      .polhi_i(bank_q[BK_POL]), .event_o(ev_w));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (rd_stat ? '0 : status_q) | ev_w;
   end

   assign irq_o = |(status_q & bank_q[BK_MASK]);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            RA_STATUS: rdata[NPIN-1:0] = status_q;
            RA_MASK:   rdata[NPIN-1:0] = bank_q[BK_MASK];
            RA_XMODE:  rdata[NPIN-1:0] = bank_q[BK_XMODE];
            RA_LEVEL:  rdata[NPIN-1:0] = bank_q[BK_LEVEL];
            RA_POL:    rdata[NPIN-1:0] = bank_q[BK_POL];
            default:   rdata = '0;
         endcase
      end
   end

   // R7
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> ((status_q & $past(ev_w)) == $past(ev_w)));
   // R2
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> ((status_q & ~$past(ev_w)) == '0));
   // R3
   irq_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((status_q != '0) && (bank_q[BK_MASK] != '0)));
   // R6
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bank_q[BK_XMODE] & bank_q[BK_LEVEL] & bank_q[BK_POL] & sync_w) != '0)
      |=> ((status_q & $past(bank_q[BK_XMODE] & bank_q[BK_LEVEL] & bank_q[BK_POL] & sync_w))
           == $past(bank_q[BK_XMODE] & bank_q[BK_LEVEL] & bank_q[BK_POL] & sync_w)));
   // R10
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [31:0] pin_i = '0;
   logic        wr_en = 0, rd_en = 0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o;

   int n_chk = 0, n_bad = 0;

   gpio_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

   always #4 clk = ~clk;

   // fields: xmode, level, pol, mask, start, end, expected status, expected irq (bit 0)
   localparam logic [255:0] VEC [6] = '{
      {32'h0,        32'h0,        32'h0,        32'h10, 32'h0,        32'h000000F0, 32'h000000F0, 32'h1},
      {32'h0,        32'h0,        32'h0,        32'h0,  32'hFFFF0000, 32'h0000FFFF, 32'hFFFFFFFF, 32'h0},
      {32'hFF,       32'h0,        32'hFF,       32'h01, 32'h0000000F, 32'h000000F0, 32'h000000F0, 32'h0},
      {32'hFF,       32'h0,        32'h0,        32'h0F, 32'h0000000F, 32'h000000F0, 32'h0000000F, 32'h1},
      {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80, 32'h0,        32'h000000A5, 32'h000000A5, 32'h1},
      {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0,  32'hFFFFFFFF, 32'hFFFF00FF, 32'h0000FF00, 32'h0}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0; wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1; addr = a;
      #1 d = rdata;
      @(negedge clk); rd_en = 0;
   endtask

   task automatic set_pins(input logic [31:0] v);
      @(negedge clk); pin_i = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R8 reset state
      check("R8 irq", {31'b0, irq_o}, 32'h0);
      rd(4'h2, d); check("R8 mask", d, 32'h0);
      rd(4'h6, d); check("R8 xmode", d, 32'h0);
      rd(4'h3, d); check("R8 status", d, 32'h0);
      // R10 idle read data
      check("R10 idle rdata", rdata, 32'h0);

      for (int i = 0; i < 6; i++) begin
         logic [255:0] v;
         v = VEC[i];
         wr(4'h5, 32'hFFFFFFFF); wr(4'h4, v[255:224]);
         wr(4'h8, 32'hFFFFFFFF); wr(4'h7, v[223:192]);
         wr(4'hB, 32'hFFFFFFFF); wr(4'hA, v[191:160]);
         wr(4'h1, 32'hFFFFFFFF); wr(4'h0, v[159:128]);
         rd(4'h6, d); check("R1 xmode readback", d, v[255:224]);
         rd(4'h2, d); check("R1 mask readback", d, v[159:128]);
         set_pins(v[127:96]);
         rd(4'h3, d);
         set_pins(v[95:64]);
         // R3 R4 R5 R6 table rows
         check("R3 irq vector", {31'b0, irq_o}, v[31:0]);
         rd(4'h3, d); check("R4/R5/R6 status vector", d, v[63:32]);
      end

      // R6 level re-latch: pins 8..15 low, level-low mode on all
      rd(4'h3, d); check("R6 level first read", d, 32'h0000FF00);
      rd(4'h3, d); check("R6 level second read", d, 32'h0000FF00);

      // back to default mode, all masked, quiet pins
      wr(4'h5, 32'hFFFFFFFF);
      wr(4'h1, 32'hFFFFFFFF);
      set_pins(32'h0);
      rd(4'h3, d);
      rd(4'h3, d); check("R2 quiet status", d, 32'h0);

      // R3 mask gating
      set_pins(32'h8);
      check("R3 masked irq", {31'b0, irq_o}, 32'h0);
      wr(4'h0, 32'h8);
      check("R3 irq after unmask", {31'b0, irq_o}, 32'h1);
      // R2 clear on read
      rd(4'h3, d); check("R2 read returns", d, 32'h8);
      check("R2 irq after read", {31'b0, irq_o}, 32'h0);
      rd(4'h3, d); check("R2 second read", d, 32'h0);

      // R7 event and read in the same cycle (pin 5 rises)
      @(negedge clk); pin_i = 32'h28;
      @(negedge clk);
      rd(4'h3, d); check("R7 collision read old", d, 32'h0);
      rd(4'h3, d); check("R7 event kept", d, 32'h20);

      // R9 zero bits have no effect, all-ones clear masks every pin
      wr(4'h1, 32'hFFFFFFFF);
      wr(4'h0, 32'h3);
      wr(4'h0, 32'h0);
      rd(4'h2, d); check("R9 set zero", d, 32'h3);
      wr(4'h1, 32'h1);
      wr(4'h1, 32'h0);
      rd(4'h2, d); check("R9 clear zero", d, 32'h2);
      wr(4'h1, 32'hFFFFFFFF);
      rd(4'h2, d); check("R9 quiesce", d, 32'h0);

      summary();
   end
endmodule